// File: doc/BRIEF.md
# Converter Word Lane Serializer

This block takes 16-bit unsigned straight-binary converter results and sends each one out over a narrow parallel lane bus. The value 0x0000 stands for black level and 0xFFFF for full-scale white. Three lane formats are available. The first sends 2 bits per rising clock edge over eight clock periods. The second sends 4 bits per rising edge over four periods. The third sends 2 bits on both clock edges over four periods. The most significant slice always goes first, and a frame-start strobe marks the first clock period of each word.

A word is loaded only at a frame boundary. A sample that arrives in the middle of a frame waits in a one-entry holding slot and goes out in the frame that follows. If a further sample arrives while the slot is still occupied, that sample is discarded and a sticky overflow flag is set. The lane format is sampled when a word is loaded, so a single word never mixes two formats.

When the active-low serial enable is low, the two lowest lanes stop driving and their pad inputs are passed to a register-access port as serial clock and serial data. During that time the upper lanes are held at zero. The serializer keeps running underneath, so any slices it produces in that time are not seen on the lanes.

Top module: `adc_lane_ser`

## Requirements
- R1: In reset, and on the first cycle after it with no sample, lane_out is 0, frame_start is 0, overflow is 0, and lane_oe is 4'b1111 when ser_en_n is 1.
- R2: Format select cfg_ddr=0 and cfg_w4=0 gives 2-bit single-edge output. A word captured at a rising edge appears on lane_out[1:0] right after that edge, bits [15:14] first. Each later rising edge brings the next lower 2 bits, for eight periods in all. lane_out[3:2] stays 0.
- R3: Format select cfg_ddr=0 and cfg_w4=1 gives 4-bit single-edge output on lane_out[3:0]. It takes four periods, bits [15:12] first and bits [3:0] last.
- R4: Format select cfg_ddr=1 gives double-edge output on lane_out[1:0] over four periods. In period k the high clock phase carries bits [15-4k:14-4k] and the low phase carries bits [13-4k:12-4k]. lane_out[3:2] stays 0.
- R5: With cfg_ddr=1 and cfg_w4=1 together, the request for 4-bit double-edge is not honoured. The output is exactly the 2-bit double-edge format of R4.
- R6: frame_start is 1 for the first clock period of each frame and 0 at all other times. With no word to send, lane_out is 0.
- R7: A sample accepted while a frame is in progress is sent in the frame that immediately follows, with no gap. A sample that arrives during the last period of a frame is also sent back to back.
- R8: A sample that arrives while the holding slot is full and no frame boundary occurs is dropped. It sets overflow, and overflow then stays 1 until reset.
- R9: cfg_w4 and cfg_ddr are sampled only at the rising edge that loads a word. A change in the middle of a frame first affects the next word.
- R10: While ser_en_n is 0, lane_oe is 4'b1100, lane_out is 0, reg_sck follows pin_in[0] and reg_dat follows pin_in[1]. While ser_en_n is 1, reg_sck and reg_dat are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; both edges are used in double-edge format |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle strobe: smp_data holds a new result |
| smp_data | input | 16 | Converter result, straight binary |
| cfg_w4 | input | 1 | 1 selects 4-bit lanes (single-edge only) |
| cfg_ddr | input | 1 | 1 selects double-edge 2-bit output |
| ser_en_n | input | 1 | Active low: hands lanes 0 and 1 to the register port |
| pin_in | input | 2 | Pad input levels of lanes 0 and 1 |
| lane_out | output | 4 | Output lane data |
| lane_oe | output | 4 | Per-lane drive enable, 1 = driving |
| frame_start | output | 1 | High during the first clock period of a frame |
| overflow | output | 1 | Sticky: a sample was lost |
| reg_sck | output | 1 | Serial clock forwarded to the register port |
| reg_dat | output | 1 | Serial data forwarded to the register port |

## Verification
Several properties are checked on every cycle. The strobe can never be high in two periods in a row. The overflow flag never clears. The upper lanes stay quiet in every 2-bit format. The lane hand-over gives the register port the pads and floats the low lanes. The loaded format matches the select lines at the loading edge, with the 4-bit double-edge request folded to 2-bit, and the format never changes outside a frame start. Only the bench scenarios can show the slice order and values in each phase, the back-to-back timing of a held sample, which sample is discarded on overflow, and that a format change in the middle of a frame takes effect one word later. The bench shows these by comparing both clock phases against a behavioural model.

// File: rtl/adc_lane_ser_pkg.sv
package adc_lane_ser_pkg;

    typedef enum logic [1:0] {
        M_SDR2 = 2'd0,
        M_SDR4 = 2'd1,
        M_DDR2 = 2'd2
    } lane_mode_e;

    typedef struct packed {
        logic       active;
        lane_mode_e mode;
    } frame_stat_t;

    // double-edge takes priority and always runs 2-bit lanes
    function automatic lane_mode_e pick_mode(input logic w4, input logic ddr);
        if (ddr)
            return M_DDR2;
        else if (w4)
            return M_SDR4;
        return M_SDR2;
    endfunction

    function automatic int frame_cycles(input lane_mode_e m, input int word_w);
        return (m == M_SDR2) ? word_w / 2 : word_w / 4;
    endfunction

endpackage

// File: rtl/als_word_buf.sv
module als_word_buf #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              take,
    output logic              has_word,
    output logic [WORD_W-1:0] word_out,
    output logic              ovf
);
    logic              pend_v;
    logic [WORD_W-1:0] pend_d;

    assign has_word = pend_v | in_valid;
    assign word_out = pend_v ? pend_d : in_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v <= 1'b0;
            pend_d <= '0;
            ovf    <= 1'b0;
        end else if (take) begin
            if (pend_v) begin
                pend_v <= in_valid;
                if (in_valid)
                    pend_d <= in_data;
            end
        end else if (in_valid) begin
            if (pend_v) begin
                ovf <= 1'b1;
            end else begin
                pend_v <= 1'b1;
                pend_d <= in_data;
            end
        end
    end
endmodule

// File: rtl/als_frame_ctrl.sv
module als_frame_ctrl
    import adc_lane_ser_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int CW = $clog2(WORD_W / 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_w4,
    input  logic              cfg_ddr,
    input  logic              has_word,
    input  logic [WORD_W-1:0] word_in,
    output logic              at_edge,
    output logic [WORD_W-1:0] word_q,
    output logic [CW-1:0]     cnt_q,
    output frame_stat_t       stat_q
);
    logic [CW-1:0] last_c;

    always_comb begin
        last_c = CW'(frame_cycles(stat_q.mode, WORD_W) - 1);
    end

    assign at_edge = !stat_q.active || (cnt_q == last_c);

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '{active: 1'b0, mode: M_SDR2};
            cnt_q  <= '0;
            word_q <= '0;
        end else if (at_edge) begin
            if (has_word) begin
                stat_q <= '{active: 1'b1, mode: pick_mode(cfg_w4, cfg_ddr)};
                cnt_q  <= '0;
                word_q <= word_in;
            end else begin
                stat_q.active <= 1'b0;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/als_lane_drive.sv
module als_lane_drive
    import adc_lane_ser_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int CW = $clog2(WORD_W / 2),
    localparam int LANES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_q,
    input  logic [CW-1:0]     cnt_q,
    input  frame_stat_t       stat_q,
    input  logic              ser_en_n,
    input  logic [1:0]        pin_in,
    output logic [LANES-1:0]  lane_out,
    output logic [LANES-1:0]  lane_oe,
    output logic              frame_start,
    output logic              reg_sck,
    output logic              reg_dat
);
    logic [1:0]       neg_q;
    logic [LANES-1:0] hi_v;
    logic [LANES-1:0] data_v;
    logic             ddr_on;

    function automatic logic [1:0] slice2(input logic [WORD_W-1:0] w, input int i);
        logic [WORD_W-1:0] t;
        t = w >> (WORD_W - 2 * (i + 1));
        return t[1:0];
    endfunction

    function automatic logic [3:0] slice4(input logic [WORD_W-1:0] w, input int i);
        logic [WORD_W-1:0] t;
        t = w >> (WORD_W - 4 * (i + 1));
        return t[3:0];
    endfunction

    assign ddr_on = stat_q.active && (stat_q.mode == M_DDR2);

    always_comb begin
        hi_v = '0;
        if (stat_q.active) begin
            case (stat_q.mode)
                M_SDR2:  hi_v = {2'b00, slice2(word_q, int'(cnt_q))};
                M_SDR4:  hi_v = slice4(word_q, int'(cnt_q));
                default: hi_v = {2'b00, slice2(word_q, 2 * int'(cnt_q))};
            endcase
        end
    end

    // odd slices of a double-edge frame, launched on the falling edge
    always_ff @(negedge clk) begin
        if (rst)
            neg_q <= 2'b00;
        else if (ddr_on)
            neg_q <= slice2(word_q, 2 * int'(cnt_q) + 1);
        else
            neg_q <= 2'b00;
    end

    // clock-phase multiplexer joins the two edge domains
    always_comb begin
        data_v = (ddr_on && !clk) ? {2'b00, neg_q} : hi_v;
    end

    always_comb begin
        if (!ser_en_n) begin
            lane_out = '0;
            lane_oe  = 4'b1100;
        end else begin
            lane_out = data_v;
            lane_oe  = 4'b1111;
        end
    end

    assign frame_start = stat_q.active && (cnt_q == '0);
    assign reg_sck     = !ser_en_n && pin_in[0];
    assign reg_dat     = !ser_en_n && pin_in[1];
endmodule

// File: rtl/adc_lane_ser.sv
module adc_lane_ser
    import adc_lane_ser_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [WORD_W-1:0] smp_data,
    input  logic              cfg_w4,
    input  logic              cfg_ddr,
    input  logic              ser_en_n,
    input  logic [1:0]        pin_in,
    output logic [3:0]        lane_out,
    output logic [3:0]        lane_oe,
    output logic              frame_start,
    output logic              overflow,
    output logic              reg_sck,
    output logic              reg_dat
);
    localparam int CW = $clog2(WORD_W / 2);

    logic              at_edge;
    logic              has_word;
    logic [WORD_W-1:0] buf_word;
    logic [WORD_W-1:0] word_q;
    logic [CW-1:0]     cnt_q;
    frame_stat_t       cur_stat;

    als_word_buf #(.WORD_W(WORD_W)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .in_valid (smp_valid),
        .in_data  (smp_data),
        .take     (at_edge),
        .has_word (has_word),
        .word_out (buf_word),
        .ovf      (overflow)
    );

    als_frame_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cfg_w4   (cfg_w4),
        .cfg_ddr  (cfg_ddr),
        .has_word (has_word),
        .word_in  (buf_word),
        .at_edge  (at_edge),
        .word_q   (word_q),
        .cnt_q    (cnt_q),
        .stat_q   (cur_stat)
    );

    als_lane_drive #(.WORD_W(WORD_W)) u_drv (
        .clk         (clk),
        .rst         (rst),
        .word_q      (word_q),
        .cnt_q       (cnt_q),
        .stat_q      (cur_stat),
        .ser_en_n    (ser_en_n),
        .pin_in      (pin_in),
        .lane_out    (lane_out),
        .lane_oe     (lane_oe),
        .frame_start (frame_start),
        .reg_sck     (reg_sck),
        .reg_dat     (reg_dat)
    );
endmodule

// File: rtl/adc_lane_ser_chk.sv
module adc_lane_ser_chk
    import adc_lane_ser_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cfg_w4,
    input logic       cfg_ddr,
    input logic       ser_en_n,
    input logic [1:0] pin_in,
    input logic [3:0] lane_out,
    input logic [3:0] lane_oe,
    input logic       frame_start,
    input logic       overflow,
    input logic       reg_sck,
    input logic       reg_dat,
    input lane_mode_e mode_q
);
    assert_fs_gap_R6: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    assert_handover_R10: assert property (@(posedge clk) disable iff (rst)
        !ser_en_n |-> (lane_oe == 4'b1100 && lane_out == 4'd0
                       && reg_sck == pin_in[0] && reg_dat == pin_in[1]));

    assert_upper_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_q != M_SDR4) |-> (lane_out[3:2] == 2'b00));

    assert_ddr_fold_R5: assert property (@(posedge clk) disable iff (rst)
        (frame_start && $past(cfg_ddr)) |-> (mode_q == M_DDR2));

    assert_w4_load_R3: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !$past(cfg_ddr) && $past(cfg_w4)) |-> (mode_q == M_SDR4));

    assert_mode_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !frame_start |-> $stable(mode_q));
endmodule

bind adc_lane_ser adc_lane_ser_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_w4      (cfg_w4),
    .cfg_ddr     (cfg_ddr),
    .ser_en_n    (ser_en_n),
    .pin_in      (pin_in),
    .lane_out    (lane_out),
    .lane_oe     (lane_oe),
    .frame_start (frame_start),
    .overflow    (overflow),
    .reg_sck     (reg_sck),
    .reg_dat     (reg_dat),
    .mode_q      (cur_stat.mode)
);

// File: tb/adc_lane_ser_tb.sv
`timescale 1ns/1ps
module adc_lane_ser_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        cfg_w4 = 1'b0;
    logic        cfg_ddr = 1'b0;
    logic        ser_en_n = 1'b1;
    logic [1:0]  pin_in = 2'b00;
    logic [3:0]  lane_out;
    logic [3:0]  lane_oe;
    logic        frame_start;
    logic        overflow;
    logic        reg_sck;
    logic        reg_dat;

    int errors = 0;
    int checks = 0;
    bit chk_en = 0;
    bit done = 0;
    string scen = "R1";

    adc_lane_ser u_dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .cfg_w4(cfg_w4), .cfg_ddr(cfg_ddr), .ser_en_n(ser_en_n), .pin_in(pin_in),
        .lane_out(lane_out), .lane_oe(lane_oe), .frame_start(frame_start),
        .overflow(overflow), .reg_sck(reg_sck), .reg_dat(reg_dat)
    );

    always #10 clk = ~clk;

    // behavioural reference: mode 0 = 2-bit single, 1 = 4-bit single, 2 = 2-bit double
    bit          m_act;
    int          m_cnt;
    int          m_mode;
    logic [15:0] m_word;
    bit          m_ovf;
    logic [15:0] pend[$];

    task automatic m_load(input logic [15:0] w);
        m_word = w;
        m_act  = 1;
        m_cnt  = 0;
        m_mode = cfg_ddr ? 2 : (cfg_w4 ? 1 : 0);
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_act = 0; m_cnt = 0; m_mode = 0; m_word = '0; m_ovf = 0;
            pend.delete();
        end else if (!m_act || m_cnt == ((m_mode == 0) ? 7 : 3)) begin
            if (pend.size() > 0) begin
                m_load(pend.pop_front());
                if (smp_valid) pend.push_back(smp_data);
            end else if (smp_valid) begin
                m_load(smp_data);
            end else begin
                m_act = 0;
            end
        end else begin
            m_cnt++;
            if (smp_valid) begin
                if (pend.size() > 0) m_ovf = 1;
                else pend.push_back(smp_data);
            end
        end
    end

    function automatic logic [3:0] exp_lane(input bit hi);
        if (!m_act) return 4'd0;
        case (m_mode)
            0: return {2'b00, m_word[15-2*m_cnt -: 2]};
            1: return m_word[15-4*m_cnt -: 4];
            default: return hi ? {2'b00, m_word[15-4*m_cnt -: 2]}
                               : {2'b00, m_word[13-4*m_cnt -: 2]};
        endcase
    endfunction

    function automatic string mode_tag();
        if (!ser_en_n) return "R10";
        if (!m_act) return "R6";
        case (m_mode)
            0: return "R2";
            1: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic cmp(input string tag, input string what, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s) %s: actual=%h expected=%h at %0t", tag, scen, what, act, exp, $time);
        end
    endtask

    task automatic check_phase(input bit hi);
        logic [3:0] el;
        el = ser_en_n ? exp_lane(hi) : 4'd0;
        cmp(mode_tag(), "lane_out", lane_out, el);
        cmp("R10", "lane_oe", lane_oe, ser_en_n ? 4'hF : 4'hC);
        cmp("R6", "frame_start", {3'b0, frame_start}, {3'b0, (m_act && m_cnt == 0)});
        cmp("R8", "overflow", {3'b0, overflow}, {3'b0, m_ovf});
        cmp("R10", "reg_port", {2'b0, reg_dat, reg_sck}, ser_en_n ? 4'd0 : {2'b0, pin_in});
    endtask

    always @(posedge clk) begin
        #5;
        if (chk_en && !done) check_phase(1'b1);
    end

    always @(negedge clk) begin
        #5;
        if (chk_en && !done) check_phase(1'b0);
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic send(input logic [15:0] d);
        smp_valid = 1'b1;
        smp_data  = d;
        tick(1);
        smp_valid = 1'b0;
    endtask

    initial begin
        tick(4);
        // R1: reset values while rst is still high
        #3;
        cmp("R1", "lane_out", lane_out, 4'd0);
        cmp("R1", "frame_start", {3'b0, frame_start}, 4'd0);
        cmp("R1", "overflow", {3'b0, overflow}, 4'd0);
        cmp("R1", "lane_oe", lane_oe, 4'hF);
        @(posedge clk); #2;
        rst = 1'b0;
        chk_en = 1;
        tick(2);

        scen = "R2 2-bit single";
        send(16'hA5C3); tick(10);
        scen = "R3 4-bit single";
        cfg_w4 = 1; send(16'h1234); tick(6);
        scen = "R3 black and white";
        send(16'h0000); send(16'hFFFF); tick(10);
        scen = "R4 double edge";
        cfg_w4 = 0; cfg_ddr = 1; send(16'h9E37); tick(6);
        scen = "R5 4-bit double request";
        cfg_w4 = 1; send(16'hF00F); tick(6);

        scen = "R7 held sample";
        cfg_w4 = 0; cfg_ddr = 0;
        send(16'h3C5A); tick(2); send(16'hC3A5); tick(20);
        scen = "R7 arrival on last slice";
        send(16'h1111); tick(6); send(16'h8421); tick(10);

        scen = "R9 mode change mid frame";
        send(16'h6B2D); tick(2);
        cfg_w4 = 1; send(16'hD2B6); tick(14);
        cfg_ddr = 1; send(16'h0F0F); tick(1); cfg_ddr = 0; cfg_w4 = 0; tick(10);

        scen = "R10 serial handover";
        cfg_w4 = 1; send(16'hBEEF);
        ser_en_n = 0; pin_in = 2'b10; tick(1); pin_in = 2'b01; tick(1); pin_in = 2'b11; tick(1);
        ser_en_n = 1; pin_in = 2'b11; tick(8);

        scen = "R8 overflow";
        cfg_w4 = 0;
        send(16'h0101); tick(1); send(16'h0202); tick(1); send(16'h0303); tick(30);
        scen = "R8 sticky after idle";
        cfg_ddr = 1; send(16'h7777); tick(8);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule